// File: doc/BRIEF.md
# Configurable External Interrupt Sense Unit

This unit sits between four external interrupt request pins and an interrupt controller core. Each pin first passes through a two-stage synchronizer. The unit then reads it in one of four sense types chosen at run time: level active high, level active low, rising edge or falling edge. It drives one pending line per pin towards the core.

Level types pass the synchronized level straight through, inverted for active low. Edge types latch the event, and the latch holds until software writes 1 to that pin's clear bit. A master enable and four per-pin enables gate the pending lines. The master enable also stops edge capture.

All control sits in one 32-bit register. The register is reached through a bare synchronous port: a select, a write strobe, write data and combinational read data.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every register bit is 0, the read data is 0 and all four pending lines are low.
- R2: In lsb-0 numbering, the register layout is as follows. The clear bits for pins 0..3 are bits 27..24. Sense types are in bits 23:22 for pin 0, 21:20 for pin 1, 19:18 for pin 2 and 17:16 for pin 3. The master enable is bit 12. The enables for pins 0..3 are bits 11..8. The clear bits and all other bits read as 0, and writes to the unused bits have no effect.
- R3: Sense type 00 is level active high. Two clocks after the pin changes, the pending line equals the pin level, and nothing is latched.
- R4: Sense type 11 is level active low. The pending line is the inverse of the synchronized pin level.
- R5: Sense type 01 is rising edge. A rising edge on the pin sets a sticky indication, which shows on the pending line three clocks after the pin rises and stays set after the pin falls.
- R6: Sense type 10 is falling edge. It behaves as R5, but on a falling edge.
- R7: Writing 1 to a pin's clear bit drops its latched indication. Writing 0 has no effect, and a clear in a level type has no effect.
- R8: If an edge is detected in the same cycle as a clear write for that pin, the indication stays set.
- R9: While the master enable is 0, all pending lines are low and no edge is captured.
- R10: A pending line is high only when that pin's enable is 1. The enable does not gate capture, so an edge caught while the pin is disabled shows up once the pin is enabled.
- R11: A write that changes a pin's sense type drops that pin's latched indication.
- R12: A write strobe without the select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, taken only with reg_sel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register image while selected, else 0 |
| irq_pin | input | 4 | Raw, asynchronous request pins |
| irq_pend | output | 4 | Pending lines to the interrupt controller |

## Verification
The pins are driven with slow level toggles, single-cycle pulses and bursts of random values, all under each of the four sense types. Level and edge types respond differently to these patterns: a short pulse in a level type leaves nothing behind, while in an edge type it remains pending. Clear writes are timed both away from an edge and onto the exact cycle an edge lands, which separates edge-wins behaviour from clear-wins behaviour. Further runs with the master enable off, with a single pin disabled and with a sense-type change show that capture, gating and mode-change flush are independent of each other.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  irq_pin,
  output logic [3:0]  irq_pend
);
  localparam int N = 4;

  logic [N-1:0]   s1, s2, s3, edge_lat, chg, clr_hit, ev;
  logic [2*N-1:0] types_q;
  logic [N-1:0]   en_q;
  logic           master_q;
  logic [31:0]    img;

  wire wr = reg_sel & reg_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= irq_pin; s2 <= s1; s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      types_q <= '0; master_q <= 1'b0; en_q <= '0;
    end else if (wr) begin
      types_q <= reg_wdata[23:16];
      master_q <= reg_wdata[12];
      en_q <= reg_wdata[11:8];
    end

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [1:0] t;
    logic rise, fall;
    assign t       = types_q[2*N-1-2*i -: 2];
    assign rise    = s2[i] & ~s3[i];
    assign fall    = ~s2[i] & s3[i];
    assign chg[i]  = wr && (reg_wdata[23-2*i -: 2] != t);
    assign clr_hit[i] = wr && reg_wdata[27-i];
    assign ev[i]   = master_q & (((t == 2'b01) & rise) | ((t == 2'b10) & fall));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          edge_lat[i] <= 1'b0;
      else if (chg[i])     edge_lat[i] <= 1'b0;
      else if (ev[i])      edge_lat[i] <= 1'b1;
      else if (clr_hit[i]) edge_lat[i] <= 1'b0;

    always_comb
      case (t)
        2'b00:   irq_pend[i] = master_q & en_q[N-1-i] & s2[i];
        2'b11:   irq_pend[i] = master_q & en_q[N-1-i] & ~s2[i];
        default: irq_pend[i] = master_q & en_q[N-1-i] & edge_lat[i];
      endcase
  end

  assign img = {8'b0, types_q, 3'b0, master_q, en_q, 8'b0};
  assign reg_rdata = reg_sel ? img : 32'b0;

  // R9
  no_masked_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |=> ((edge_lat & ~$past(edge_lat)) == '0));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((~edge_lat & $past(edge_lat)) == '0));

  // R12
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(img));

  // R11
  type_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((edge_lat & $past(chg)) == '0));
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [3:0] irq_pin = 0;
  logic [3:0] irq_pend;
  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  ext_irq_sense u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin), .irq_pend(irq_pend));

  always #10 clk = ~clk;

  int m1[4], m2[4], m3[4], mt[4], men[4], mlat[4];
  int mmaster;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m1[i] = 0; m2[i] = 0; m3[i] = 0; mt[i] = 0; men[i] = 0; mlat[i] = 0;
      end
      mmaster = 0;
    end else begin
      int w, nt, ev;
      w = reg_sel && reg_wr;
      for (int i = 0; i < 4; i++) begin
        ev = mmaster && ((mt[i] == 1 && m2[i] == 1 && m3[i] == 0) ||
                         (mt[i] == 2 && m2[i] == 0 && m3[i] == 1));
        nt = w ? int'(reg_wdata[23-2*i -: 2]) : mt[i];
        if (w && nt != mt[i]) mlat[i] = 0;
        else if (ev) mlat[i] = 1;
        else if (w && reg_wdata[27-i]) mlat[i] = 0;
        mt[i] = nt;
        if (w) men[i] = reg_wdata[11-i];
        m3[i] = m2[i]; m2[i] = m1[i]; m1[i] = irq_pin[i];
      end
      if (w) mmaster = reg_wdata[12];
    end
  end

  function automatic logic [3:0] exp_pend();
    logic [3:0] p;
    for (int i = 0; i < 4; i++) begin
      int v;
      v = (mt[i] == 0) ? m2[i] : (mt[i] == 3) ? !m2[i] : mlat[i];
      p[i] = mmaster && men[i] && v;
    end
    return p;
  endfunction

  function automatic logic [31:0] exp_img();
    logic [31:0] r;
    r = 0;
    for (int i = 0; i < 4; i++) begin
      r[23-2*i -: 2] = mt[i][1:0];
      r[11-i] = men[i][0];
    end
    r[12] = mmaster[0];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, {28'b0, irq_pend}, {28'b0, exp_pend()});
    chk(cur_req, reg_rdata, reg_sel ? exp_img() : 32'b0);
  end

  function automatic logic [31:0] word(input logic [1:0] t0, t1, t2, t3,
                                       input logic m, input logic [3:0] en, input logic [3:0] clr);
    logic [31:0] r;
    r = 0;
    r[23:22] = t0; r[21:20] = t1; r[19:18] = t2; r[17:16] = t3;
    r[12] = m;
    for (int i = 0; i < 4; i++) begin
      r[11-i] = en[i];
      r[27-i] = clr[i];
    end
    return r;
  endfunction

  task automatic wreg(logic [31:0] d);
    reg_sel = 1; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    reg_sel = 1; #1;
    cur_req = "R1"; chk("R1", reg_rdata, 0); chk("R1", {28'b0, irq_pend}, 0);
    reg_sel = 0;
    cur_req = "R2"; wreg(32'hFFFF_FFFF);
    reg_sel = 1; #1; chk("R2", reg_rdata, 32'h00FF_1F00); reg_sel = 0;
    cur_req = "R12"; reg_wr = 1; reg_wdata = 0; cyc(1); reg_wr = 0;
    reg_sel = 1; #1; chk("R12", reg_rdata, 32'h00FF_1F00); reg_sel = 0;

    cur_req = "R3"; wreg(word(0, 0, 0, 0, 1, 4'hF, 0));
    irq_pin = 4'b0101; cyc(1); chk("R3", {28'b0, irq_pend}, 0);
    cyc(1); chk("R3", {28'b0, irq_pend}, 4'b0101);
    irq_pin = 4'b1010; cyc(3); irq_pin = 0; cyc(3);

    cur_req = "R4"; wreg(word(3, 3, 3, 3, 1, 4'hF, 0));
    cyc(1); chk("R4", {28'b0, irq_pend}, 4'hF);
    irq_pin = 4'b0011; cyc(2); chk("R4", {28'b0, irq_pend}, 4'b1100);
    cur_req = "R7"; wreg(word(3, 3, 3, 3, 1, 4'hF, 4'hF)); cyc(1);
    chk("R7", {28'b0, irq_pend}, 4'b1100);
    irq_pin = 0; cyc(3);

    cur_req = "R5"; wreg(word(1, 1, 2, 2, 1, 4'hF, 0));
    irq_pin = 4'b0001; cyc(2); chk("R5", {28'b0, irq_pend}, 0);
    cyc(1); chk("R5", {28'b0, irq_pend}, 4'b0001);
    irq_pin = 0; cyc(4); chk("R5", {28'b0, irq_pend}, 4'b0001);
    cur_req = "R6"; irq_pin = 4'b0100; cyc(4); irq_pin = 0; cyc(4);
    chk("R6", {28'b0, irq_pend}, 4'b0101);
    cur_req = "R7"; wreg(word(1, 1, 2, 2, 1, 4'hF, 0)); cyc(1);
    chk("R7", {28'b0, irq_pend}, 4'b0101);
    wreg(word(1, 1, 2, 2, 1, 4'hF, 4'b0001)); cyc(1);
    chk("R7", {28'b0, irq_pend}, 4'b0100);
    wreg(word(1, 1, 2, 2, 1, 4'hF, 4'b0100));

    cur_req = "R8"; irq_pin = 4'b0010; cyc(2);
    wreg(word(1, 1, 2, 2, 1, 4'hF, 4'b0010)); cyc(1);
    chk("R8", {28'b0, irq_pend}, 4'b0010);
    irq_pin = 0; wreg(word(1, 1, 2, 2, 1, 4'hF, 4'hF)); cyc(3);

    cur_req = "R9"; wreg(word(1, 1, 2, 2, 0, 4'hF, 0));
    irq_pin = 4'b0011; cyc(4); irq_pin = 4'b0000; cyc(4);
    wreg(word(1, 1, 2, 2, 1, 4'hF, 0)); cyc(1);
    chk("R9", {28'b0, irq_pend}, 0);

    cur_req = "R10"; wreg(word(1, 1, 2, 2, 1, 4'b1110, 0));
    irq_pin = 4'b0001; cyc(4); chk("R10", {28'b0, irq_pend}, 0);
    wreg(word(1, 1, 2, 2, 1, 4'hF, 0)); chk("R10", {28'b0, irq_pend}, 4'b0001);

    cur_req = "R11"; wreg(word(2, 1, 2, 2, 1, 4'hF, 0)); cyc(1);
    chk("R11", {28'b0, irq_pend}, 0);
    irq_pin = 0; cyc(4);

    cur_req = "R6";
    for (int k = 0; k < 400; k++) begin
      irq_pin = 4'($urandom);
      if (k % 37 == 0) wreg(word(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                                 1'($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom)));
      else cyc(1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule